// File: doc/BRIEF.md
# Prioritized UART Interrupt Identification

This block merges the interrupt causes of a serial port into one request line and an identification byte for the host. Five causes are tracked: a receiver line error, receive data available, a receive character timeout, the transmit holding register going empty, and a change on the modem control lines. Each class has its own enable bit. The highest-priority cause that is both pending and enabled is encoded into a 3-bit identity. Each cause is removed by the host access that services it.

The data path, the FIFOs and the register decoding sit outside this block. The block sees the source conditions as levels or one-cycle event pulses, and it sees the host accesses as one-cycle strobes. It also times the FIFO-mode receive timeout itself. For that it counts bit-period ticks against four character lengths, and the character length comes from the current line format.

Top module: `uart_irq_id`

## Requirements
- R1: `irq_o` is high exactly when at least one enabled cause is pending. Enable bit 0 covers both data available and timeout, bit 1 covers holding register empty, bit 2 covers line error, and bit 3 covers modem change. A disabled cause stays latched but has no effect on `irq_o` or on the identification.
- R2: `iir_o` is captured on the clock edge where `iir_rd_i` is high and holds at all other times. Bit 0 of the captured value is 0 when an enabled cause is pending and 1 when none is.
- R3: The identity in `iir_o[3:1]` is the code of the highest pending enabled cause. The order from highest to lowest, with codes, is: line error 011, data available 010, timeout 110, holding register empty 001, modem change 000. When no cause is pending the field is 000.
- R4: `iir_o[7:6]` reads 11 when `fifo_en_i` was high at the capturing edge and 00 otherwise. `iir_o[5:4]` is always 00.
- R5: A `ls_err_evt_i` pulse latches the line error cause. A `lsr_rd_i` strobe clears it. If the event and the strobe fall on the same edge, the event wins.
- R6: The data available cause follows the `rx_ready_i` level with no latching.
- R7: In FIFO mode, while `rx_nonempty_i` is high, the block counts `bit_tick_i` pulses. The timeout cause becomes pending once the count reaches four character lengths. The count restarts on `rbr_rd_i` or `rx_push_i`, and it is held at zero when the FIFO is empty or FIFO mode is off.
- R8: The character length in bit periods is 1 + data bits + parity bit + stop bits. `line_fmt_i[1:0]` gives the data bits (00 = 5 through 11 = 8), `line_fmt_i[2]` selects two stop bits, and `line_fmt_i[3]` enables parity. 8 data bits with no parity and one stop bit gives a 40-tick timeout; 5 data bits with parity and two stop bits gives 36 ticks.
- R9: A rising edge of `thr_empty_i` latches the holding register empty cause. It is cleared by `thr_wr_i`, or by an identification read that reports this cause as the highest. A read that reports another cause leaves it pending.
- R10: A `ms_chg_evt_i` pulse latches the modem change cause. A `msr_rd_i` strobe clears it, and the event wins on a tie.
- R11: After reset no cause is pending, `irq_o` is 0 and `iir_o` is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en_i | input | 4 | Per-class enable bits |
| fifo_en_i | input | 1 | FIFO mode active |
| line_fmt_i | input | 4 | Parity enable, two stop bits, data-bits code |
| ls_err_evt_i | input | 1 | Receive error event pulse |
| lsr_rd_i | input | 1 | Host read of line status |
| rx_ready_i | input | 1 | Receive data available level |
| rx_nonempty_i | input | 1 | Receive FIFO holds data |
| rx_push_i | input | 1 | New character stored in receive FIFO |
| rbr_rd_i | input | 1 | Host read of receive data |
| bit_tick_i | input | 1 | One pulse per bit period |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| thr_wr_i | input | 1 | Host write of transmit data |
| ms_chg_evt_i | input | 1 | Modem line change event pulse |
| msr_rd_i | input | 1 | Host read of modem status |
| iir_rd_i | input | 1 | Host read of identification |
| iir_o | output | 8 | Captured identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the one where every cause is pending at the same time, including a timeout. A timeout needs dozens of uninterrupted bit ticks with the FIFO non-empty and no read or push in between. A directed sequence builds this state by starting a count, letting it run to the limit while the other causes are raised, and then servicing the causes one at a time. This shows the priority order and that a read reporting a higher cause leaves the empty-register cause in place. A long random phase with sparse strobes and frequent ticks is then checked every cycle against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MS   = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LS   = 3'b011,
    ID_TMO  = 3'b110
  } irq_id_e;

  typedef struct packed {
    logic ls;
    logic rda;
    logic tmo;
    logic thre;
    logic ms;
  } cause_t;

  // bit periods in one character: start + data + parity + stop
  function automatic logic [3:0] char_bits(input logic [3:0] fmt);
    return 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
  endfunction

endpackage

// File: rtl/uart_irq_chartimer.sv
module uart_irq_chartimer
  import uart_irq_pkg::*;
#(
  parameter int TMO_CHARS = 4,
  parameter int MAX_CHAR  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en_i,
  input  logic       nonempty_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [3:0] fmt_i,
  output logic       tmo_o
);
  localparam int CW = $clog2(TMO_CHARS * MAX_CHAR + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  assign limit  = CW'(char_bits(fmt_i)) * CW'(TMO_CHARS);
  assign cnt_en = tick_i && (cnt_q < limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!fifo_en_i || !nonempty_i || restart_i) cnt_d = '0;
    else if (cnt_en)                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tmo_o = fifo_en_i && nonempty_i && (cnt_q >= limit);

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources (
  input  logic clk,
  input  logic rst_n,
  input  logic ls_evt_i,
  input  logic lsr_rd_i,
  input  logic ms_evt_i,
  input  logic msr_rd_i,
  input  logic thr_empty_i,
  input  logic thr_wr_i,
  input  logic thre_ack_i,
  output logic ls_o,
  output logic ms_o,
  output logic thre_o
);
  localparam int NSTICKY = 2;

  logic [NSTICKY-1:0] st_set, st_clr, st_d, st_q;
  logic               prev_q, thre_q, thre_d;

  assign st_set = {ms_evt_i, ls_evt_i};
  assign st_clr = {msr_rd_i, lsr_rd_i};

  generate
    for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
      assign st_d[g] = st_set[g] | (st_q[g] & ~st_clr[g]);
    end
  endgenerate

  assign thre_d = (thr_empty_i & ~prev_q) | (thre_q & ~thr_wr_i & ~thre_ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      thre_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      thre_q <= thre_d;
      prev_q <= thr_empty_i;
    end
  end

  assign ls_o   = st_q[0];
  assign ms_o   = st_q[1];
  assign thre_o = thre_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  cause_t  pend_i,
  output logic    any_o,
  output irq_id_e id_o
);
  always_comb begin
    any_o = |pend_i;
    if      (pend_i.ls)   id_o = ID_LS;
    else if (pend_i.rda)  id_o = ID_RDA;
    else if (pend_i.tmo)  id_o = ID_TMO;
    else if (pend_i.thre) id_o = ID_THRE;
    else                  id_o = ID_MS;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int TMO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_en_i,
  input  logic       fifo_en_i,
  input  logic [3:0] line_fmt_i,
  input  logic       ls_err_evt_i,
  input  logic       lsr_rd_i,
  input  logic       rx_ready_i,
  input  logic       rx_nonempty_i,
  input  logic       rx_push_i,
  input  logic       rbr_rd_i,
  input  logic       bit_tick_i,
  input  logic       thr_empty_i,
  input  logic       thr_wr_i,
  input  logic       ms_chg_evt_i,
  input  logic       msr_rd_i,
  input  logic       iir_rd_i,
  output logic [7:0] iir_o,
  output logic       irq_o
);
  logic    ls_pend, ms_pend, thre_pend, tmo_pend, thre_ack, any;
  cause_t  masked;
  irq_id_e id;
  logic [7:0] iir_q, iir_d;

  uart_irq_sources u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .ls_evt_i   (ls_err_evt_i),
    .lsr_rd_i   (lsr_rd_i),
    .ms_evt_i   (ms_chg_evt_i),
    .msr_rd_i   (msr_rd_i),
    .thr_empty_i(thr_empty_i),
    .thr_wr_i   (thr_wr_i),
    .thre_ack_i (thre_ack),
    .ls_o       (ls_pend),
    .ms_o       (ms_pend),
    .thre_o     (thre_pend)
  );

  uart_irq_chartimer #(.TMO_CHARS(TMO_CHARS)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_i (fifo_en_i),
    .nonempty_i(rx_nonempty_i),
    .restart_i (rbr_rd_i | rx_push_i),
    .tick_i    (bit_tick_i),
    .fmt_i     (line_fmt_i),
    .tmo_o     (tmo_pend)
  );

  always_comb begin
    masked.ls   = ls_pend    & irq_en_i[2];
    masked.rda  = rx_ready_i & irq_en_i[0];
    masked.tmo  = tmo_pend   & irq_en_i[0];
    masked.thre = thre_pend  & irq_en_i[1];
    masked.ms   = ms_pend    & irq_en_i[3];
  end

  uart_irq_prio u_prio (
    .pend_i(masked),
    .any_o (any),
    .id_o  (id)
  );

  assign thre_ack = iir_rd_i & any & (id == ID_THRE);

  always_comb begin
    iir_d = iir_q;
    if (iir_rd_i) iir_d = {{2{fifo_en_i}}, 2'b00, id, ~any};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iir_q <= 8'h01;
    else        iir_q <= iir_d;
  end

  assign iir_o = iir_q;
  assign irq_o = any;

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lsr_rd_i,
  input logic       ls_err_evt_i,
  input logic       ms_chg_evt_i,
  input logic       thr_empty_i,
  input logic       rbr_rd_i,
  input logic       iir_rd_i,
  input logic       fifo_en_i,
  input logic       irq_o,
  input logic [7:0] iir_o,
  input logic       ls_pend,
  input logic       ms_pend,
  input logic       thre_pend,
  input logic       tmo_pend
);
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && !irq_o) |=> iir_o[0]);                              // R1
  AST_IIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_rd_i |=> $stable(iir_o));                                    // R2
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd_i |=> (iir_o[7:6] == {2{$past(fifo_en_i)}}) && (iir_o[5:4] == 2'b00)); // R4
  AST_LS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && !ls_err_evt_i) |=> !ls_pend);                        // R5
  AST_TMO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd_i |=> !tmo_pend);                                          // R7
  AST_THRE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_empty_i) |=> thre_pend);                                // R9
  AST_MS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ms_chg_evt_i |=> ms_pend);                                        // R10
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lsr_rd_i    (lsr_rd_i),
  .ls_err_evt_i(ls_err_evt_i),
  .ms_chg_evt_i(ms_chg_evt_i),
  .thr_empty_i (thr_empty_i),
  .rbr_rd_i    (rbr_rd_i),
  .iir_rd_i    (iir_rd_i),
  .fifo_en_i   (fifo_en_i),
  .irq_o       (irq_o),
  .iir_o       (iir_o),
  .ls_pend     (ls_pend),
  .ms_pend     (ms_pend),
  .thre_pend   (thre_pend),
  .tmo_pend    (tmo_pend)
);

// File: tb/sim_uart_irq_id.sv
`timescale 1ns/1ps
module sim_uart_irq_id;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] irq_en = 4'h0;
  logic fifo_en = 1'b0;
  logic [3:0] fmt = 4'b0011;
  logic ls_evt = 0, lsr_rd = 0, rx_ready = 0, rx_nonempty = 0, rx_push = 0;
  logic rbr_rd = 0, bit_tick = 0, thr_empty = 0, thr_wr = 0, ms_evt = 0;
  logic msr_rd = 0, iir_rd = 0;
  logic [7:0] iir;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_id u0 (
    .clk(clk), .rst_n(rst_n), .irq_en_i(irq_en), .fifo_en_i(fifo_en),
    .line_fmt_i(fmt), .ls_err_evt_i(ls_evt), .lsr_rd_i(lsr_rd),
    .rx_ready_i(rx_ready), .rx_nonempty_i(rx_nonempty), .rx_push_i(rx_push),
    .rbr_rd_i(rbr_rd), .bit_tick_i(bit_tick), .thr_empty_i(thr_empty),
    .thr_wr_i(thr_wr), .ms_chg_evt_i(ms_evt), .msr_rd_i(msr_rd),
    .iir_rd_i(iir_rd), .iir_o(iir), .irq_o(irq)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic int m_len(input logic [3:0] f);
    return 1 + 5 + int'(f[1:0]) + int'(f[3]) + (f[2] ? 2 : 1);
  endfunction

  function automatic logic [7:0] m_byte(input logic ls, rda, tmo, thre, ms,
                                        input logic [3:0] en, input logic fe);
    logic [2:0] code;
    logic any;
    any = 1'b1;
    if      (ls & en[2])   code = 3'b011;
    else if (rda & en[0])  code = 3'b010;
    else if (tmo & en[0])  code = 3'b110;
    else if (thre & en[1]) code = 3'b001;
    else if (ms & en[3])   code = 3'b000;
    else begin code = 3'b000; any = 1'b0; end
    return {fe, fe, 2'b00, code, ~any};
  endfunction

  logic m_ls, m_ms, m_thre, m_prev;
  int   m_cnt;
  logic [7:0] m_iir;
  logic model_on = 1'b0;

  function automatic logic m_tmo();
    return fifo_en && rx_nonempty && (m_cnt >= 4 * m_len(fmt));
  endfunction

  function automatic logic [7:0] m_now();
    return m_byte(m_ls, rx_ready, m_tmo(), m_thre, m_ms, irq_en, fifo_en);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ls <= 0; m_ms <= 0; m_thre <= 0; m_prev <= 0; m_cnt <= 0; m_iir <= 8'h01;
    end else begin
      logic [7:0] b;
      b = m_now();
      m_ls   <= ls_evt | (m_ls & ~lsr_rd);
      m_ms   <= ms_evt | (m_ms & ~msr_rd);
      m_thre <= (thr_empty & ~m_prev) |
                (m_thre & ~thr_wr & ~(iir_rd && !b[0] && b[3:1] == 3'b001));
      m_prev <= thr_empty;
      if (!fifo_en || !rx_nonempty || rbr_rd || rx_push) m_cnt <= 0;
      else if (bit_tick && m_cnt < 4 * m_len(fmt))      m_cnt <= m_cnt + 1;
      if (iir_rd) m_iir <= b;
    end
  end

  always @(posedge clk) begin
    #1;
    if (model_on) begin
      checks++;
      if (irq !== ~m_now()[0]) begin
        errors++;
        $display("FAIL R1 model irq: got %0b exp %0b", irq, ~m_now()[0]);
      end
      checks++;
      if (iir !== m_iir) begin
        errors++;
        $display("FAIL R3 model iir: got %02h exp %02h", iir, m_iir);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h exp %02h", req, got, exp);
    end
  endtask

  // apply strobes at negedge, wait one edge, sample after it
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic clr_strobes();
    @(negedge clk);
    ls_evt = 0; lsr_rd = 0; rx_push = 0; rbr_rd = 0; thr_wr = 0;
    ms_evt = 0; msr_rd = 0; iir_rd = 0;
  endtask

  task automatic read_iir(input string req, input logic [7:0] exp);
    @(negedge clk); iir_rd = 1;
    cyc();
    chk(req, iir, exp);
    clr_strobes();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    cyc();
    chk("R11 reset irq", {7'd0, irq}, 8'h00);
    chk("R11 reset iir", iir, 8'h01);

    // R1 masking, R5 line error latch and clear
    @(negedge clk); ls_evt = 1;
    cyc(); chk("R1 masked", {7'd0, irq}, 8'h00);
    clr_strobes(); irq_en = 4'b0100;
    cyc(); chk("R1 enabled", {7'd0, irq}, 8'h01);
    read_iir("R3 line error code, R4 non-fifo", 8'h06);
    @(negedge clk); lsr_rd = 1;
    cyc(); chk("R5 cleared", {7'd0, irq}, 8'h00);
    clr_strobes();
    read_iir("R2 idle", 8'h01);

    // R9 holding empty rise and write clear
    irq_en = 4'b0010; thr_empty = 1;
    cyc(); chk("R9 set on rise", {7'd0, irq}, 8'h01);
    @(negedge clk); thr_wr = 1;
    cyc(); chk("R9 write clears", {7'd0, irq}, 8'h00);
    clr_strobes();
    cyc(); chk("R9 level stays high no reset", {7'd0, irq}, 8'h00);

    // R6 data available follows level
    irq_en = 4'b0001; @(negedge clk); rx_ready = 1;
    cyc(); chk("R6 level", {7'd0, irq}, 8'h01);
    @(negedge clk); rx_ready = 0;
    cyc(); chk("R6 drop", {7'd0, irq}, 8'h00);

    // R7 / R8 timeout for 8N1 = 40 ticks
    fifo_en = 1; rx_nonempty = 1; fmt = 4'b0011;
    @(negedge clk); rx_push = 1;
    clr_strobes(); bit_tick = 1;
    repeat (39) @(posedge clk); #1;
    chk("R7 before limit", {7'd0, irq}, 8'h00);
    cyc(); chk("R8 40 ticks", {7'd0, irq}, 8'h01);
    read_iir("R4 fifo bits with timeout", 8'hCC);
    @(negedge clk); rbr_rd = 1; bit_tick = 0;
    cyc(); chk("R7 read clears", {7'd0, irq}, 8'h00);
    clr_strobes();

    // R8 5 data bits, parity, two stops = 36 ticks
    fmt = 4'b1100; bit_tick = 1;
    repeat (35) @(posedge clk); #1;
    chk("R8 35 ticks", {7'd0, irq}, 8'h00);
    cyc(); chk("R8 36 ticks", {7'd0, irq}, 8'h01);
    @(negedge clk); bit_tick = 0; fifo_en = 0;
    cyc(); chk("R7 off outside fifo", {7'd0, irq}, 8'h00);

    // R3 full priority walk with every cause pending
    fifo_en = 1; fmt = 4'b0011; irq_en = 4'hF; thr_empty = 0;
    @(negedge clk); rx_push = 1;
    clr_strobes(); bit_tick = 1; ls_evt = 1; ms_evt = 1;
    clr_strobes(); thr_empty = 1; rx_ready = 1;
    repeat (45) @(posedge clk);
    @(negedge clk); bit_tick = 0;
    read_iir("R3 line error first", 8'hC6);
    @(negedge clk); lsr_rd = 1; clr_strobes();
    read_iir("R3 data available second", 8'hC4);
    @(negedge clk); rx_ready = 0;
    read_iir("R3 timeout third", 8'hCC);
    @(negedge clk); rbr_rd = 1; clr_strobes();
    read_iir("R9 empty survives other reads", 8'hC2);
    read_iir("R9 read reporting it clears, R10 modem last", 8'hC0);
    @(negedge clk); msr_rd = 1; ms_evt = 1;
    cyc(); chk("R10 event wins over read", {7'd0, irq}, 8'h01);
    clr_strobes(); msr_rd = 1;
    clr_strobes();
    read_iir("R10 cleared", 8'hC1);

    // random phase checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ls_evt    = ($urandom % 40) == 0;
      lsr_rd    = ($urandom % 12) == 0;
      ms_evt    = ($urandom % 40) == 0;
      msr_rd    = ($urandom % 12) == 0;
      thr_wr    = ($urandom % 10) == 0;
      iir_rd    = ($urandom % 4) == 0;
      rbr_rd    = ($urandom % 80) == 0;
      rx_push   = ($urandom % 90) == 0;
      bit_tick  = ($urandom % 3) != 0;
      if (($urandom % 15) == 0) thr_empty = ~thr_empty;
      if (($urandom % 20) == 0) rx_ready = ~rx_ready;
      if (($urandom % 60) == 0) rx_nonempty = ~rx_nonempty;
      if (($urandom % 300) == 0) fifo_en = ~fifo_en;
      if (($urandom % 200) == 0) irq_en = 4'($urandom);
      if (($urandom % 400) == 0) fmt = 4'($urandom);
    end
    clr_strobes();
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule